// File: doc/BRIEF.md
# Sleep State Power Plane Controller

This block follows the system through its working state and four sleep depths: standby, suspend-to-RAM, suspend-to-disk and soft-off. It drives three active-low power-plane controls and one active-low suspend warning. The deeper the sleep, the more planes are switched off, and each deeper plane control implies the shallower ones. Before any plane goes down, the warning output goes low a fixed number of cycles early. Memory devices use that time to move to self refresh, and other devices use it to isolate their outputs.

A sleep request is accepted only while the system is running. The request names its target depth with a two-bit code. Once asleep, the system returns to running on a wake from one of three sources: the power button, the PCI Express sideband wake, or the modem ring input. The ring input only counts when a ring-wake enable bit is set. That bit is kept in the resume-well register file, so only the resume-well reset clears it.

A power-button override forces soft-off from any state. A low processor thermal-trip input also forces soft-off, with no warning period. It outranks every other input and stays latched until the resume-well reset.

Top module: `sleep_plane_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, the controller is running: all four outputs are high.
- R2: A `sleep_req` pulse in the running state with `sleep_type` 0 (standby) keeps all planes on. Code 1 (RAM) drives `ram_off_n` low. Code 2 (disk) drives `ram_off_n` and `disk_off_n` low. Code 3 (soft-off) drives all three plane controls low.
- R3: The plane controls are nested. `soft_off_n` low implies `disk_off_n` low, and `disk_off_n` low implies `ram_off_n` low.
- R4: `susp_warn_n` goes low on the edge that samples the request. The target plane controls go low exactly `LEAD_CYCLES` edges later. No plane control is ever low while `susp_warn_n` is high.
- R5: A wake in any sleep state releases all plane controls on the sampling edge. `susp_warn_n` returns high on the following edge, and the controller is then running.
- R6: The wake sources are `wake_button`, `wake_pcie`, and `wake_ring` when the ring enable is set. `wake_ring` has no effect while the enable is clear.
- R7: A cycle with `ring_en_we` high loads `ring_en_val` into the ring enable. The enable keeps its value through every sleep state, and only `rst_n` clears it.
- R8: Wake inputs have no effect while running or during the warning period.
- R9: A `sleep_req` has no effect unless the controller is running. The target chosen at entry is kept.
- R10: `button_override` high drives all outputs low on the next edge, from any state, with no warning period.
- R11: `cpu_trip_n` low drives all outputs low on the next edge. It takes priority over requests, overrides and wakes. It is latched, so only `rst_n` returns the controller to running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Resume-well clock |
| rst_n | input | 1 | Resume-well reset, asynchronous, active low |
| sleep_req | input | 1 | One-cycle sleep request |
| sleep_type | input | 2 | Target depth: 0 standby, 1 RAM, 2 disk, 3 soft-off |
| wake_button | input | 1 | Power button wake event |
| wake_ring | input | 1 | Modem ring wake event |
| wake_pcie | input | 1 | PCI Express sideband wake event |
| ring_en_we | input | 1 | Write strobe for the ring wake enable |
| ring_en_val | input | 1 | Value written to the ring wake enable |
| button_override | input | 1 | Power button held past the override time |
| cpu_trip_n | input | 1 | Processor thermal trip, active low |
| ram_off_n | output | 1 | Low in RAM, disk and soft-off states |
| disk_off_n | output | 1 | Low in disk and soft-off states |
| soft_off_n | output | 1 | Low in soft-off only |
| susp_warn_n | output | 1 | Low in every state other than running |

## Verification
All four outputs are decoded straight from the registered state. A wrong state therefore shows at the pins on the same edge that produced it. A wrong plane pattern or warning level points to either a mis-mapped target or a missed transition. A warning period of the wrong length shows as a plane edge one or more cycles off the `LEAD_CYCLES` count. A lost thermal latch shows later: it appears only when a wake arrives after the trip input has gone back high, and the planes then come back up when they should stay down.

// File: rtl/sleep_plane_pkg.sv
package sleep_plane_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_WARN,
        ST_STBY,
        ST_RAM,
        ST_DISK,
        ST_OFF,
        ST_RESUME
    } pstate_t;

    typedef enum logic [1:0] {
        REQ_STBY = 2'd0,
        REQ_RAM  = 2'd1,
        REQ_DISK = 2'd2,
        REQ_OFF  = 2'd3
    } req_t;

    typedef struct packed {
        pstate_t state;
        req_t    tgt;
        logic    trip;
    } fsm_t;

    // active-high view of the outputs
    typedef struct packed {
        logic ram_off;
        logic disk_off;
        logic soft_off;
        logic warn;
    } plane_t;

    function automatic pstate_t req_to_state(req_t r);
        case (r)
            REQ_STBY: return ST_STBY;
            REQ_RAM:  return ST_RAM;
            REQ_DISK: return ST_DISK;
            default:  return ST_OFF;
        endcase
    endfunction

endpackage

// File: rtl/sleep_lead_timer.sv
module sleep_lead_timer #(
    parameter int unsigned LEAD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int unsigned CW = (LEAD_CYCLES > 1) ? $clog2(LEAD_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(LEAD_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == '0);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    generate
        if (LEAD_CYCLES > 1) begin : g_multi
            // R4
            start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                start |=> !done);
        end
    endgenerate

endmodule

// File: rtl/wake_qualify.sv
module wake_qualify (
    input  logic clk,
    input  logic rst_n,
    input  logic button,
    input  logic ring,
    input  logic pcie,
    input  logic en_we,
    input  logic en_val,
    output logic wake_any
);
    logic ring_en_d, ring_en_q;

    always_comb begin
        ring_en_d = ring_en_q;
        if (en_we) begin
            ring_en_d = en_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_en_q <= 1'b0;
        end else begin
            ring_en_q <= ring_en_d;
        end
    end

    assign wake_any = button | pcie | (ring & ring_en_q);

    // R7
    ring_en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we |=> $stable(ring_en_q));

endmodule

// File: rtl/plane_encoder.sv
module plane_encoder
    import sleep_plane_pkg::*;
(
    input  pstate_t state,
    output plane_t  planes
);
    always_comb begin
        planes          = '0;
        planes.warn     = (state != ST_RUN);
        planes.ram_off  = (state == ST_RAM) || (state == ST_DISK) || (state == ST_OFF);
        planes.disk_off = (state == ST_DISK) || (state == ST_OFF);
        planes.soft_off = (state == ST_OFF);
    end
endmodule

// File: rtl/sleep_plane_ctrl.sv
module sleep_plane_ctrl
    import sleep_plane_pkg::*;
#(
    parameter int unsigned LEAD_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic [1:0] sleep_type,
    input  logic       wake_button,
    input  logic       wake_ring,
    input  logic       wake_pcie,
    input  logic       ring_en_we,
    input  logic       ring_en_val,
    input  logic       button_override,
    input  logic       cpu_trip_n,
    output logic       ram_off_n,
    output logic       disk_off_n,
    output logic       soft_off_n,
    output logic       susp_warn_n
);
    fsm_t   fsm_d, fsm_q;
    logic   lead_start;
    logic   lead_done;
    logic   wake_any;
    plane_t planes;

    sleep_lead_timer #(.LEAD_CYCLES(LEAD_CYCLES)) i_lead (
        .clk   (clk),
        .rst_n (rst_n),
        .start (lead_start),
        .done  (lead_done)
    );

    wake_qualify i_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .button   (wake_button),
        .ring     (wake_ring),
        .pcie     (wake_pcie),
        .en_we    (ring_en_we),
        .en_val   (ring_en_val),
        .wake_any (wake_any)
    );

    always_comb begin
        fsm_d      = fsm_q;
        lead_start = 1'b0;
        if (fsm_q.trip || !cpu_trip_n) begin
            fsm_d.trip  = 1'b1;
            fsm_d.state = ST_OFF;
        end else if (button_override) begin
            fsm_d.state = ST_OFF;
        end else begin
            case (fsm_q.state)
                ST_RUN: begin
                    if (sleep_req) begin
                        fsm_d.state = ST_WARN;
                        fsm_d.tgt   = req_t'(sleep_type);
                        lead_start  = 1'b1;
                    end
                end
                ST_WARN: begin
                    if (lead_done) begin
                        fsm_d.state = req_to_state(fsm_q.tgt);
                    end
                end
                ST_STBY, ST_RAM, ST_DISK, ST_OFF: begin
                    if (wake_any) begin
                        fsm_d.state = ST_RESUME;
                    end
                end
                default: begin
                    fsm_d.state = ST_RUN;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_RUN, tgt: REQ_STBY, trip: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    plane_encoder i_enc (
        .state  (fsm_q.state),
        .planes (planes)
    );

    assign ram_off_n   = ~planes.ram_off;
    assign disk_off_n  = ~planes.disk_off;
    assign soft_off_n  = ~planes.soft_off;
    assign susp_warn_n = ~planes.warn;

    // R3
    plane_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_off_n |-> !disk_off_n) and (!disk_off_n |-> !ram_off_n));

    // R4
    warn_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_off_n |-> !susp_warn_n);

    // R5
    release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_warn_n) |-> (ram_off_n && $past(ram_off_n)));

    // R8
    run_wake_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_RUN && !sleep_req && !button_override && cpu_trip_n)
        |=> (susp_warn_n && ram_off_n));

    // R9
    req_target_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state != ST_RUN) |=> $stable(fsm_q.tgt));

    // R10
    override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        button_override |=> (!soft_off_n && !susp_warn_n));

    // R11
    trip_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_trip_n |=> !soft_off_n);

    // R11
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.trip |=> (fsm_q.trip && !soft_off_n));

endmodule

// File: tb/test_sleep_plane_ctrl.sv
module test_sleep_plane_ctrl;
    localparam int LEAD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic [1:0] sleep_type = 2'd0;
    logic wake_button = 1'b0, wake_ring = 1'b0, wake_pcie = 1'b0;
    logic ring_en_we = 1'b0, ring_en_val = 1'b0;
    logic button_override = 1'b0;
    logic cpu_trip_n = 1'b1;
    logic ram_off_n, disk_off_n, soft_off_n, susp_warn_n;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sleep_plane_ctrl #(.LEAD_CYCLES(LEAD)) i_sleep_plane_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_type(sleep_type),
        .wake_button(wake_button), .wake_ring(wake_ring), .wake_pcie(wake_pcie),
        .ring_en_we(ring_en_we), .ring_en_val(ring_en_val),
        .button_override(button_override), .cpu_trip_n(cpu_trip_n),
        .ram_off_n(ram_off_n), .disk_off_n(disk_off_n),
        .soft_off_n(soft_off_n), .susp_warn_n(susp_warn_n)
    );

    // reference model: 0 run, 1 warning, 10 standby, 13 RAM, 14 disk, 15 soft-off, 20 resuming
    int  m_st = 0;
    int  m_cnt = 0;
    int  m_tgt = 0;
    bit  m_trip = 1'b0;
    bit  m_ring = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_tgt = 0; m_trip = 1'b0; m_ring = 1'b0;
        end else begin
            bit w;
            w = wake_button || wake_pcie || (wake_ring && m_ring);
            if (ring_en_we) m_ring = ring_en_val;
            if (m_trip || !cpu_trip_n) begin
                m_trip = 1'b1; m_st = 15;
            end else if (button_override) begin
                m_st = 15;
            end else if (m_st == 0) begin
                if (sleep_req) begin m_st = 1; m_cnt = 0; m_tgt = int'(sleep_type); end
            end else if (m_st == 1) begin
                m_cnt++;
                if (m_cnt == LEAD) m_st = (m_tgt == 0) ? 10 : 12 + m_tgt;
            end else if (m_st >= 10 && m_st <= 15) begin
                if (w) m_st = 20;
            end else begin
                m_st = 0;
            end
        end
    end

    function automatic logic [3:0] model_out();
        logic [3:0] o;
        o[3] = !(m_st >= 13 && m_st <= 15);
        o[2] = !(m_st == 14 || m_st == 15);
        o[1] = !(m_st == 15);
        o[0] = (m_st == 0);
        return o;
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model every clock, a quarter period after the edge
    always @(posedge clk) begin
        #5;
        if (!finished) begin
            logic [3:0] e;
            e = model_out();
            check("R2 planes vs model", {ram_off_n, disk_off_n, soft_off_n, 1'b0}, {e[3:1], 1'b0});
            check("R4 warning vs model", {3'b000, susp_warn_n}, {3'b000, e[0]});
        end
    end

    // outputs packed as {ram_off_n, disk_off_n, soft_off_n, susp_warn_n}
    task automatic chk(input string req, input logic [3:0] exp);
        check(req, {ram_off_n, disk_off_n, soft_off_n, susp_warn_n}, exp);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go_sleep(input logic [1:0] t);
        sleep_req = 1'b1; sleep_type = t;
        tick(1);
        sleep_req = 1'b0;
        tick(LEAD);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(2);
        chk("R1 in reset", 4'b1111);
        rst_n = 1'b1;
        tick(1);
        chk("R1 after reset", 4'b1111);

        // wake while running
        wake_button = 1'b1; wake_pcie = 1'b1; tick(1); wake_button = 1'b0; wake_pcie = 1'b0;
        chk("R8 wake in run", 4'b1111);

        // RAM entry with a second request and a wake inside the warning period
        sleep_req = 1'b1; sleep_type = 2'd1; tick(1); sleep_req = 1'b0;
        chk("R4 warning first", 4'b1110);
        sleep_req = 1'b1; sleep_type = 2'd3; wake_button = 1'b1;
        tick(1);
        sleep_req = 1'b0; wake_button = 1'b0;
        chk("R8 wake during warning", 4'b1110);
        tick(LEAD - 2);
        chk("R4 planes still up", 4'b1110);
        tick(1);
        chk("R2 RAM depth", 4'b0110);
        chk("R9 target kept", 4'b0110);

        sleep_req = 1'b1; sleep_type = 2'd3; tick(1); sleep_req = 1'b0;
        chk("R9 request while asleep", 4'b0110);

        wake_pcie = 1'b1; tick(1); wake_pcie = 1'b0;
        chk("R5 planes released", 4'b1110);
        tick(1);
        chk("R5 warning released", 4'b1111);

        // disk depth and ring enable
        go_sleep(2'd2);
        chk("R2 disk depth", 4'b0010);
        wake_ring = 1'b1; tick(1); wake_ring = 1'b0;
        chk("R6 ring disabled", 4'b0010);
        ring_en_we = 1'b1; ring_en_val = 1'b1; tick(1); ring_en_we = 1'b0; ring_en_val = 1'b0;
        wake_ring = 1'b1; tick(1); wake_ring = 1'b0;
        chk("R6 ring enabled", 4'b1110);
        tick(1);
        chk("R6 back to run", 4'b1111);

        // standby
        go_sleep(2'd0);
        chk("R2 standby depth", 4'b1110);
        tick(2);
        chk("R2 standby held", 4'b1110);
        wake_button = 1'b1; tick(1); wake_button = 1'b0;
        tick(1);
        chk("R6 button wake", 4'b1111);

        // override from run, ring enable survives soft-off
        button_override = 1'b1; tick(1); button_override = 1'b0;
        chk("R10 override from run", 4'b0000);
        wake_ring = 1'b1; tick(1); wake_ring = 1'b0;
        chk("R7 enable kept", 4'b1110);
        tick(1);
        chk("R7 resumed", 4'b1111);

        // override during warning
        sleep_req = 1'b1; sleep_type = 2'd1; tick(1); sleep_req = 1'b0;
        button_override = 1'b1; tick(1); button_override = 1'b0;
        chk("R10 override in warning", 4'b0000);
        wake_button = 1'b1; tick(1); wake_button = 1'b0; tick(1);
        go_sleep(2'd3);
        chk("R2 soft-off depth", 4'b0000);
        wake_pcie = 1'b1; tick(1); wake_pcie = 1'b0; tick(1);
        chk("R5 out of soft-off", 4'b1111);

        // thermal trip beats everything and latches
        cpu_trip_n = 1'b0; sleep_req = 1'b1; sleep_type = 2'd0; button_override = 1'b1;
        tick(1);
        cpu_trip_n = 1'b1; sleep_req = 1'b0; button_override = 1'b0;
        chk("R11 trip entry", 4'b0000);
        wake_button = 1'b1; tick(1); wake_button = 1'b0;
        chk("R11 button ignored", 4'b0000);
        wake_pcie = 1'b1; wake_ring = 1'b1; tick(1); wake_pcie = 1'b0; wake_ring = 1'b0;
        tick(3);
        chk("R11 latched", 4'b0000);

        rst_n = 1'b0; tick(1);
        chk("R1 reset again", 4'b1111);
        rst_n = 1'b1; tick(1);
        chk("R11 cleared by reset", 4'b1111);

        // ring enable cleared by reset
        go_sleep(2'd1);
        wake_ring = 1'b1; tick(1); wake_ring = 1'b0;
        chk("R7 enable cleared", 4'b0110);
        wake_button = 1'b1; tick(1); wake_button = 1'b0; tick(2);
        chk("R5 final run", 4'b1111);

        finish_run();
    end
endmodule